// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. A word is stored on each write-clock edge where the write enable is high and the buffer is not full. A word is moved to the registered output on each read-clock edge where the read enable is high and the buffer is not empty. The output keeps its value between reads.

Five active-low status flags report the fill level: empty, full, half-full, almost-empty and almost-full. The almost-empty and almost-full thresholds come from two offset inputs. A separate loader drives these inputs and holds them steady. The package provides a function that returns the customary default offset for a given depth. Depth must be a power of two, and depth and word width are both parameters.

Each side keeps a binary pointer one bit wider than the address and publishes it in Gray code. The other side receives it through a two-flop synchronizer. Full, almost-full and half-full are computed in the write domain. Empty and almost-empty are computed in the read domain. Because of the synchronizer delay, a flag may stay in its cautious state for a few cycles after the other side has moved.

Top module: `async_fifo_flags`

## Requirements
- R1: While rst_ni is low, both pointers are cleared, empty_no and aempty_no are low, and full_no, afull_no and half_no are high.
- R2: Words leave the buffer in the order they were accepted. This holds under concurrent traffic on the two clocks.
- R3: empty_no is low while no word is stored. It goes high a few read-clock cycles after the first accepted write, once the write pointer has crossed the synchronizer.
- R4: A read enable while empty_no is low is ignored. rd_data_o keeps its value and no word is consumed.
- R5: With no reads, full_no goes low on the write-clock edge of exactly the DEPTH-th write. A write while full_no is low stores nothing.
- R6: After the first read from a full buffer, full_no returns high once the read pointer has crossed into the write domain.
- R7: aempty_no is low while the stored count is at most empty_ofs_i (n). It is high once n+1 or more words are stored.
- R8: afull_no is low while the stored count is at least DEPTH minus full_ofs_i (m).
- R9: half_no is low while the stored count is above DEPTH/2. For DEPTH 16, this starts at the 9th word.
- R10: dflt_offset(depth) returns 31 for 256, 63 for 512, 127 for 1024 and above, and depth/8-1 for smaller depths of at least 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| full_ofs_i | input | log2(DEPTH) | Almost-full offset m |
| full_no | output | 1 | Low when full |
| afull_no | output | 1 | Low when count >= DEPTH-m |
| half_no | output | 1 | Low when count > DEPTH/2 |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered output word |
| empty_ofs_i | input | log2(DEPTH) | Almost-empty offset n |
| empty_no | output | 1 | Low when empty |
| aempty_no | output | 1 | Low when count <= n |

## Verification
The hardest case to reach from the ports is a flag crossing a threshold exactly when the count changes by one while the opposite domain is quiet. Under concurrent traffic the synchronizer delay hides the exact crossing edge. The bench therefore steps the buffer one word at a time through the full range, first filling and then draining, for several offset pairs. After each step it checks the flags of the active domain at once, then waits for the pointers to settle and checks the flags of the other domain. A separate phase runs irregular concurrent traffic on two unrelated clocks and checks word order against a queue.

// File: rtl/fifo_flags_pkg.sv
package fifo_flags_pkg;

  typedef struct packed {
    logic full_n;
    logic afull_n;
    logic half_n;
  } wr_flags_t;

  typedef struct packed {
    logic empty_n;
    logic aempty_n;
  } rd_flags_t;

  // customary almost-flag offset for a given depth
  function automatic int unsigned dflt_offset(int unsigned depth);
    if (depth >= 1024) return 127;
    else if (depth >= 512) return 63;
    else if (depth >= 256) return 31;
    else if (depth >= 16) return depth / 8 - 1;
    else return 0;
  endfunction

endpackage

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_o[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import fifo_flags_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] full_ofs_i,
  input  logic [PW-1:0] rbin_i,
  output logic          wr_acc_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output wr_flags_t     flags_o
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
  localparam logic [PW:0]   DEPTH_X  = (PW + 1)'(DEPTH);

  logic [PW-1:0] wbin_q, wbin_nx, cnt;
  logic [PW:0]   thr;
  logic [PW-1:0] wgray_q;
  wr_flags_t     flags_q;

  assign wr_acc_o = wr_en_i & flags_q.full_n;
  assign wbin_nx  = wbin_q + PW'(wr_acc_o);
  assign cnt      = wbin_nx - rbin_i;
  assign thr      = DEPTH_X - {{(PW + 1 - AW){1'b0}}, full_ofs_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      flags_q <= '{full_n: 1'b1, afull_n: 1'b1, half_n: 1'b1};
    end else begin
      wbin_q          <= wbin_nx;
      wgray_q         <= wbin_nx ^ (wbin_nx >> 1);
      flags_q.full_n  <= (cnt != FULL_CNT);
      flags_q.afull_n <= ({1'b0, cnt} < thr);
      flags_q.half_n  <= (cnt <= HALF_CNT);
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign flags_o = flags_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wbin_q - rbin_i) <= FULL_CNT);
  p_full_afull_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_q.full_n |-> !flags_q.afull_n);
  p_full_half_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_q.full_n |-> !flags_q.half_n);
  p_wgray_onebit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_flags_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] empty_ofs_i,
  input  logic [PW-1:0] wbin_i,
  output logic          rd_acc_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output rd_flags_t     flags_o
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0] rbin_q, rbin_nx, cnt;
  logic [PW-1:0] rgray_q;
  rd_flags_t     flags_q;

  assign rd_acc_o = rd_en_i & flags_q.empty_n;
  assign rbin_nx  = rbin_q + PW'(rd_acc_o);
  assign cnt      = wbin_i - rbin_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      flags_q <= '{empty_n: 1'b0, aempty_n: 1'b0};
    end else begin
      rbin_q           <= rbin_nx;
      rgray_q          <= rbin_nx ^ (rbin_nx >> 1);
      flags_q.empty_n  <= (cnt != '0);
      flags_q.aempty_n <= (cnt > {1'b0, empty_ofs_i});
    end
  end

  // the memory reads the address held before the pointer advances
  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign flags_o = flags_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wbin_i - rbin_q) <= FULL_CNT);
  p_empty_aempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_q.empty_n |-> !flags_q.aempty_n);
  p_rgray_onebit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/async_fifo_flags.sv
module async_fifo_flags
  import fifo_flags_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 18
) (
  input  logic                      wclk_i,
  input  logic                      rclk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [$clog2(DEPTH)-1:0]  full_ofs_i,
  output logic                      full_no,
  output logic                      afull_no,
  output logic                      half_no,
  input  logic                      rd_en_i,
  output logic [DATA_W-1:0]         rd_data_o,
  input  logic [$clog2(DEPTH)-1:0]  empty_ofs_i,
  output logic                      empty_no,
  output logic                      aempty_no
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic          wr_acc, rd_acc;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wbin_r, rbin_w;
  wr_flags_t     wflags;
  rd_flags_t     rflags;

  fifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) i_wr_ctl (
    .clk_i(wclk_i), .rst_ni, .wr_en_i, .full_ofs_i, .rbin_i(rbin_w),
    .wr_acc_o(wr_acc), .waddr_o(waddr), .wgray_o(wgray), .flags_o(wflags)
  );

  fifo_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) i_rd_ctl (
    .clk_i(rclk_i), .rst_ni, .rd_en_i, .empty_ofs_i, .wbin_i(wbin_r),
    .rd_acc_o(rd_acc), .raddr_o(raddr), .rgray_o(rgray), .flags_o(rflags)
  );

  fifo_ptr_sync #(.W(PW)) i_sync_w2r (
    .clk_i(rclk_i), .rst_ni, .gray_i(wgray), .bin_o(wbin_r)
  );

  fifo_ptr_sync #(.W(PW)) i_sync_r2w (
    .clk_i(wclk_i), .rst_ni, .gray_i(rgray), .bin_o(rbin_w)
  );

  fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) i_mem (
    .wclk_i, .we_i(wr_acc), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rclk_i, .rst_ni, .re_i(rd_acc), .raddr_i(raddr), .rdata_o(rd_data_o)
  );

  assign full_no   = wflags.full_n;
  assign afull_no  = wflags.afull_n;
  assign half_no   = wflags.half_n;
  assign empty_no  = rflags.empty_n;
  assign aempty_no = rflags.aempty_n;

  p_idle_read_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && rd_en_i) |=> $stable(rd_data_o));
endmodule

// File: tb/test_async_fifo_flags.sv
module test_async_fifo_flags;
  localparam int unsigned D  = 16;
  localparam int unsigned W  = 8;
  localparam int unsigned AW = 4;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [AW-1:0] full_ofs = '0, empty_ofs = '0;
  logic full_n, afull_n, half_n, empty_n, aempty_n;
  logic [W-1:0] rd_data;

  int checks = 0, fails = 0, cnt = 0;
  logic [W-1:0] model[$];

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  async_fifo_flags #(.DEPTH(D), .DATA_W(W)) i_async_fifo_flags (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .full_ofs_i(full_ofs),
    .full_no(full_n), .afull_no(afull_n), .half_no(half_n),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .empty_ofs_i(empty_ofs),
    .empty_no(empty_n), .aempty_no(aempty_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_wr();
    chk("R5 full_no", full_n, cnt != D);
    chk("R8 afull_no", afull_n, !(cnt >= int'(D) - int'(full_ofs)));
    chk("R9 half_no", half_n, !(cnt > D / 2));
  endtask

  task automatic chk_rd();
    chk("R3 empty_no", empty_n, cnt != 0);
    chk("R7 aempty_no", aempty_n, cnt > int'(empty_ofs));
  endtask

  task automatic settle();
    repeat (10) @(negedge wclk);
  endtask

  task automatic push(input logic [W-1:0] d);
    logic acc;
    @(negedge wclk);
    wr_en = 1'b1; wr_data = d; acc = full_n;
    @(negedge wclk);
    wr_en = 1'b0;
    if (acc) begin model.push_back(d); cnt++; end
  endtask

  task automatic pop();
    logic acc;
    logic [W-1:0] prev, exp;
    @(negedge rclk);
    rd_en = 1'b1; acc = empty_n; prev = rd_data;
    @(negedge rclk);
    rd_en = 1'b0;
    if (acc) begin
      exp = model.pop_front(); cnt--;
      chk("R2 order", rd_data, exp);
    end else begin
      chk("R4 idle read keeps data", rd_data, prev);
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge wclk);
    chk("R1 empty_no", empty_n, 0);
    chk("R1 aempty_no", aempty_n, 0);
    chk("R1 full_no", full_n, 1);
    chk("R1 afull_no", afull_n, 1);
    chk("R1 half_no", half_n, 1);
    rst_n = 1'b1;

    // R10 default offsets
    chk("R10 dflt 256", int'(fifo_flags_pkg::dflt_offset(256)), 31);
    chk("R10 dflt 512", int'(fifo_flags_pkg::dflt_offset(512)), 63);
    chk("R10 dflt 1024", int'(fifo_flags_pkg::dflt_offset(1024)), 127);
    chk("R10 dflt 4096", int'(fifo_flags_pkg::dflt_offset(4096)), 127);
    chk("R10 dflt 16", int'(fifo_flags_pkg::dflt_offset(16)), 1);

    for (int k = 0; k < 4; k++) begin
      empty_ofs = AW'((k * 5) % D);
      full_ofs  = AW'((k * 7 + 3) % D);
      settle();
      chk_wr(); chk_rd();
      for (int i = 0; i < int'(D); i++) begin
        push(W'(i * 3 + k * 17));
        chk_wr();
        if (i == 0) chk("R3 empty_no before sync", empty_n, 0);
        settle();
        chk_rd();
      end
      // R5 write while full is dropped
      push(8'hEE);
      chk("R5 count held when full", cnt, D);
      chk("R5 full_no held", full_n, 0);
      for (int i = 0; i < int'(D); i++) begin
        pop();
        chk_rd();
        settle();
        chk_wr();
        if (i == 0) chk("R6 full_no after first read", full_n, 1);
      end
      pop();
      chk("R4 empty_no stays low", empty_n, 0);
      settle();
    end

    // concurrent traffic, R2
    begin
      logic wdone;
      wdone = 1'b0;
      empty_ofs = 4'd1; full_ofs = 4'd1;
      fork
        begin
          logic [W-1:0] seq;
          seq = '0;
          for (int c = 0; c < 400; c++) begin
            @(negedge wclk);
            wr_en = ($urandom % 4) != 0;
            wr_data = seq;
            if (wr_en && full_n) begin model.push_back(seq); seq++; end
          end
          @(negedge wclk);
          wr_en = 1'b0;
          wdone = 1'b1;
        end
        begin
          logic pend;
          logic [W-1:0] exp;
          pend = 1'b0; exp = '0;
          for (int c = 0; c < 3000; c++) begin
            @(negedge rclk);
            if (pend) chk("R2 order under traffic", rd_data, exp);
            if (wdone && model.size() == 0 && empty_n == 1'b0 && !pend) break;
            rd_en = ($urandom % 3) != 0;
            pend = rd_en && empty_n;
            if (pend) begin
              if (model.size() == 0) chk("R2 unexpected word", 1, 0);
              else exp = model.pop_front();
            end
          end
          rd_en = 1'b0;
        end
      join
      chk("R2 all words drained", model.size(), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule